// File: doc/BRIEF.md
# Write-combining store buffer with timed flush

This block sits between a producer of narrow sequential writes (bytes, halfwords or 32-bit words) and a 32-bit shared memory port. Instead of issuing one memory write per item, it gathers consecutive items into a packing register that mirrors one aligned memory word. Each of the four byte lanes carries its own write-enable tag. When the last lane of the word is filled, the packed word enters a small FIFO. The FIFO is emptied toward memory in bursts of whole words. A burst starts when the fill level reaches a high-water mark, when a timeout expires, or when software asks for a flush.

A start command loads a byte address, which may be unaligned. Items are then placed at consecutive byte addresses from there. An item that crosses a word boundary is split: its low part completes the current word and its high part begins the next one. A flush, or the start command itself, pushes any half-filled word out with only its filled lanes enabled. The block then holds `busy` high until every buffered byte has been granted by memory. Two timeout policies are selectable. One re-arms on every write and trips after a short idle gap. The other starts at the first write into an empty buffer and trips after a fixed longer window, whatever writes follow. A write that needs a FIFO slot when none is free is discarded and raises a sticky overflow flag.

Top module: `wc_fifo`

## Requirements
- R1: After reset, `mem_req`, `busy` and `overflow` are all 0.
- R2: Items with `wr_size` 0, 1 or 2 carry 1, 2 or 4 bytes taken little-endian from `wr_data[7:0]` upward. After a flush, memory holds exactly those bytes at consecutive byte addresses starting at the start address, whatever the mix of sizes.
- R3: Every memory write uses a word-aligned address (`mem_addr[1:0]` = 0). Byte lane i of `mem_data` and `mem_be[i]` map to byte address `mem_addr`+i. Items that cross a word boundary are split over two consecutive words, and this holds for every start offset 0 to 3.
- R4: A partially filled word is written with only its filled lanes enabled. Memory bytes that were not written keep their old values. `mem_be` is never 0 while `mem_req` is 1.
- R5: `cmd_flush` or `cmd_start` makes `busy` go high in the next cycle. `busy` stays high until all buffered data has been granted. The address given with `cmd_start` applies to the first write after `busy` falls.
- R6: Writes presented while `busy` is 1 are discarded and do not reach memory.
- R7: With no timeout pending, `mem_req` is 0 while fewer than 8 words are buffered. It rises two cycles after the write that brings the FIFO to 8 words is presented.
- R8: A burst delivers at most 8 granted words. `mem_req` then drops for at least one cycle.
- R9: With `tmo_mode` = 0, a buffered item is requested in the 17th cycle after the last write was presented. Writes spaced 10 cycles apart never trip the timeout.
- R10: With `tmo_mode` = 1, the request appears in the 129th cycle after the first write into an empty buffer was presented, even though writes keep arriving every 10 cycles.
- R11: A write that would complete a word while the FIFO holds 16 words is discarded and sets `overflow`. The flag stays set through flushes and is cleared by the next `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Flush, then load `cmd_addr` as the new write pointer |
| cmd_flush | input | 1 | Flush without changing the write pointer |
| cmd_addr | input | 32 | Byte address for `cmd_start` |
| tmo_mode | input | 1 | 0: idle-gap timeout (16 cycles), 1: fixed window from first write (128 cycles) |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| wr_data | input | 32 | Write data, least significant byte first |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_be | output | 4 | Per-lane byte enables |
| mem_gnt | input | 1 | Memory accepts the current request this cycle |
| busy | output | 1 | Flush in progress |
| overflow | output | 1 | Sticky: a write was lost to a full FIFO |

## Verification
Two functions can act in the same clock. The first case is a write that completes a word entering the FIFO while a granted burst removes the oldest entry. The sweeps provoke it by streaming items while the grant toggles every cycle, and the full memory image is compared with a byte model. The second case is a timeout trip coinciding with the push of a partial word. It is judged by the exact cycle in which the request first appears, and by the enables of the partial word observed at the memory port.

// File: rtl/wc_fifo.sv
module wc_fifo #(
  parameter int DEPTH = 16,
  parameter int HWM   = 8,
  parameter int BURST = 8,
  parameter int TMO_A = 16,
  parameter int TMO_B = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_flush,
  input  logic [31:0] cmd_addr,
  input  logic        tmo_mode,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_data,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_data,
  output logic [3:0]  mem_be,
  input  logic        mem_gnt,
  output logic        busy,
  output logic        overflow
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int AW   = $clog2(DEPTH);
  localparam int BW   = $clog2(BURST);
  localparam int TMAX = (TMO_A > TMO_B) ? TMO_A : TMO_B;
  localparam int TW   = $clog2(TMAX);

  logic [29:0] e_wa [DEPTH];
  logic [3:0]  e_be [DEPTH];
  logic [31:0] e_d  [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;

  logic [31:0] ptr, nxt_addr;
  logic        nxt_load;
  logic [3:0]  pk_be;
  logic [31:0] pk_d;
  logic        burst_on, tmo_pend, tmr_run;
  logic [BW-1:0] bcnt;
  logic [TW-1:0] tmr;

  logic [3:0] nmask;
  logic [2:0] nbytes;
  always_comb begin
    case (wr_size)
      2'd0:    begin nmask = 4'b0001; nbytes = 3'd1; end
      2'd1:    begin nmask = 4'b0011; nbytes = 3'd2; end
      default: begin nmask = 4'b1111; nbytes = 3'd4; end
    endcase
  end

  wire [1:0]  off   = ptr[1:0];
  wire [7:0]  lmask = {4'b0000, nmask} << off;
  wire [31:0] wd_m  = wr_data & {{8{nmask[3]}}, {8{nmask[2]}}, {8{nmask[1]}}, {8{nmask[0]}}};
  wire [63:0] wdat  = {32'b0, wd_m} << {off, 3'b000};

  logic [31:0] mdat;
  always_comb
    for (int i = 0; i < 4; i++)
      mdat[8*i +: 8] = lmask[i] ? wdat[8*i +: 8] : pk_d[8*i +: 8];
  wire [3:0] mbe = pk_be | lmask[3:0];

  wire full     = (count == CW'(DEPTH));
  wire empty    = (count == '0);
  wire complete = lmask[3];
  wire cmd_ok   = (cmd_start | cmd_flush) & ~busy;
  wire wr_try   = wr_en & ~busy;
  wire wr_acc   = wr_try & ~(complete & full);
  wire ovf_hit  = wr_try & complete & full;
  wire pk_any   = (pk_be != 4'b0000);

  wire [TW-1:0] lim = tmo_mode ? TW'(TMO_B - 1) : TW'(TMO_A - 1);
  wire trip = tmr_run & (tmr == lim);

  wire part_push = (busy | tmo_pend | trip) & ~wr_acc & pk_any & ~full;
  wire push      = (wr_acc & complete) | part_push;
  wire pop       = mem_req & mem_gnt;
  wire trig      = (count >= CW'(HWM)) | trip | busy | tmo_pend;
  wire buf_empty = empty & ~pk_any;

  assign mem_req  = burst_on & ~empty;
  assign mem_addr = {e_wa[rp], 2'b00};
  assign mem_data = e_d[rp];
  assign mem_be   = e_be[rp];

  always_ff @(posedge clk) begin
    if (push) begin
      e_wa[wp] <= ptr[31:2];
      e_be[wp] <= part_push ? pk_be : mbe;
      e_d[wp]  <= part_push ? pk_d : mdat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      ptr <= '0; nxt_addr <= '0; nxt_load <= 1'b0;
      pk_be <= '0; pk_d <= '0;
      busy <= 1'b0; overflow <= 1'b0;
      burst_on <= 1'b0; bcnt <= '0; tmo_pend <= 1'b0;
      tmr_run <= 1'b0; tmr <= '0;
    end else begin
      count <= count + CW'(push) - CW'(pop);
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);

      if (wr_acc) begin
        ptr <= ptr + {29'b0, nbytes};
        if (complete) begin
          pk_be <= lmask[7:4];
          pk_d  <= wdat[63:32];
        end else begin
          pk_be <= mbe;
          pk_d  <= mdat;
        end
      end else if (part_push) begin
        pk_be <= 4'b0000;
      end

      if (cmd_ok) begin
        busy     <= 1'b1;
        nxt_load <= cmd_start;
        nxt_addr <= cmd_addr;
      end else if (busy && empty && !pk_any && !push) begin
        busy <= 1'b0;
        if (nxt_load) ptr <= nxt_addr;
      end

      if (cmd_ok && cmd_start) overflow <= 1'b0;
      else if (ovf_hit)        overflow <= 1'b1;

      tmo_pend <= (trip | tmo_pend) & ~part_push & pk_any;

      if (!burst_on) begin
        burst_on <= trig;
        bcnt     <= '0;
      end else if (pop) begin
        if (bcnt == BW'(BURST - 1)) burst_on <= 1'b0;
        else                        bcnt <= bcnt + BW'(1);
      end else if (empty && !tmo_pend && !busy) begin
        burst_on <= 1'b0;
      end

      if (wr_acc && (!tmo_mode || buf_empty)) begin
        tmr_run <= 1'b1;
        tmr     <= '0;
      end else if (trip) begin
        tmr_run <= 1'b0;
      end else if (tmr_run) begin
        tmr <= tmr + TW'(1);
      end
    end
  end

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !(cmd_start && !busy) |=> overflow);
  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && full && complete |=> overflow);
  // R8
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && bcnt == BW'(BURST - 1) |=> !mem_req);
  // R4
  lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_be != 4'b0000);
  // R5
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> empty && !pk_any);
  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !nxt_load |=> $stable(ptr));
  // R7
  hwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count >= CW'(HWM) && !burst_on |=> burst_on);
  // R11
  always_ff @(posedge clk)
    if (rst_n) level_chk: assert (count <= CW'(DEPTH));
endmodule

// File: tb/wc_fifo_bench.sv
`timescale 1ns/1ps
module wc_fifo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_flush = 0, tmo_mode = 0, wr_en = 0;
  logic [31:0] cmd_addr = 0, wr_data = 0;
  logic [1:0] wr_size = 0;
  logic mem_req, busy, overflow;
  logic [31:0] mem_addr, mem_data;
  logic [3:0] mem_be;
  logic [1:0] gm = 0;
  logic ph = 0;
  wire gnt = (gm == 2'd1) || (gm == 2'd2 && ph);

  always #4 clk = ~clk;

  wc_fifo u_wc_fifo (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_flush(cmd_flush),
    .cmd_addr(cmd_addr), .tmo_mode(tmo_mode), .wr_en(wr_en), .wr_size(wr_size),
    .wr_data(wr_data), .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .mem_gnt(gnt), .busy(busy), .overflow(overflow));

  integer total = 0, bad = 0, cyc = 0, misalign = 0;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [3:0] last_be = 0;
  integer bp = 0;
  logic done = 0;

  function automatic logic [7:0] initv(int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= initv(i);
    end else if (mem_req && gnt) begin
      for (int j = 0; j < 4; j++)
        if (mem_be[j]) mem[{mem_addr[7:2], 2'(j)}] <= mem_data[8*j +: 8];
      last_be <= mem_be;
      if (mem_addr[1:0] != 2'b00) misalign <= misalign + 1;
    end
  end
  always @(negedge clk) ph <= ~ph;

  task automatic chk(input logic ok, input string tag, input integer act, input integer exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exv);
    end
  endtask

  task automatic cmp_mem(input string tag);
    integer nerr = 0, fa = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== expm[i]) begin nerr++; if (fa < 0) fa = i; end
    total++;
    if (nerr != 0) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, fa, mem[fa], expm[fa]);
    end
  endtask

  task automatic wait_idle();
    integer n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic start_cmd(input integer a);
    cmd_start = 1; cmd_addr = 32'(a);
    @(negedge clk); cmd_start = 0;
    wait_idle();
    bp = a;
  endtask

  task automatic flush_cmd();
    cmd_flush = 1;
    @(negedge clk); cmd_flush = 0;
    wait_idle();
  endtask

  task automatic drive(input integer sz, input logic [31:0] d, input logic keep);
    integer nb;
    wr_en = 1; wr_size = 2'(sz); wr_data = d;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (keep) begin
      for (int j = 0; j < nb; j++) expm[(bp + j) & 255] = d[8*j +: 8];
      bp = bp + nb;
    end
  endtask

  task automatic wr(input integer sz, input logic [31:0] d, input logic keep);
    drive(sz, d, keep);
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    integer t0, t1, n;
    for (int i = 0; i < 256; i++) expm[i] = initv(i);
    repeat (4) @(negedge clk);
    chk(mem_req == 0 && busy == 0 && overflow == 0, "R1 reset outputs", {mem_req, busy, overflow}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4: sweep start offsets and size patterns with toggling grant
    gm = 2;
    for (int off = 0; off < 4; off++)
      for (int p = 0; p < 4; p++) begin
        start_cmd(64 + off);
        for (int k = 0; k < 9; k++)
          wr((p == 3) ? (k % 3) : p,
             {8'(k * 7 + off), 8'(k * 5 + p), 8'(k * 3 + 1), 8'(k + off * 16 + p * 64)}, 1);
        flush_cmd();
        cmp_mem($sformatf("R2 R3 R4 sweep off=%0d pat=%0d", off, p));
      end
    chk(misalign == 0, "R3 aligned addresses", misalign, 0);

    // R4: lone byte at lane 3
    gm = 1;
    start_cmd(131);
    wr(0, 32'h0000005A, 1);
    flush_cmd();
    chk(last_be == 4'b1000, "R4 partial enables", last_be, 8);
    cmp_mem("R4 neighbours untouched");

    // R5 R6: start while memory withheld
    gm = 0;
    start_cmd(144);
    wr(0, 32'h11, 1); wr(0, 32'h22, 1); wr(0, 32'h33, 1);
    cmd_start = 1; cmd_addr = 32'd192;
    @(negedge clk); cmd_start = 0;
    repeat (30) @(negedge clk);
    chk(busy == 1, "R5 busy held while data pending", busy, 1);
    chk(mem[144] == initv(144), "R5 data not yet written", mem[144], initv(144));
    wr(0, 32'h77, 0);
    gm = 1;
    wait_idle();
    chk(busy == 0, "R5 busy released", busy, 0);
    cmp_mem("R6 dropped write absent");
    bp = 192;
    wr(0, 32'h44, 1);
    flush_cmd();
    chk(mem[192] == 8'h44, "R5 new start address", mem[192], 8'h44);
    cmp_mem("R5 R6 image");

    // R7: high-water mark timing
    repeat (40) @(negedge clk);
    start_cmd(0);
    for (int k = 0; k < 7; k++) wr(2, 32'hA0B0C000 + 32'(k), 1);
    repeat (3) @(negedge clk);
    chk(mem_req == 0, "R7 below mark", mem_req, 0);
    wr(2, 32'hA0B0C007, 1);
    chk(mem_req == 0, "R7 one cycle after 8th", mem_req, 0);
    @(negedge clk);
    chk(mem_req == 1, "R7 two cycles after 8th", mem_req, 1);
    flush_cmd();
    cmp_mem("R7 image");

    // R8: burst cap
    gm = 0;
    start_cmd(32);
    for (int k = 0; k < 9; k++) wr(2, 32'h5500AA00 + 32'(k), 1);
    drive(2, 32'h5500AA09, 1);
    gm = 1;
    n = 0;
    if (mem_req) n++;
    @(negedge clk); wr_en = 0;
    while (mem_req && n < 20) begin n++; @(negedge clk); end
    chk(n == 8, "R8 grants in burst", n, 8);
    flush_cmd();
    cmp_mem("R8 image");

    // R9: idle-gap timeout
    tmo_mode = 0;
    repeat (40) @(negedge clk);
    t0 = cyc;
    wr(0, 32'hC3, 1);
    t1 = -1;
    for (int c = 0; c < 40 && t1 < 0; c++) begin
      if (mem_req) t1 = cyc;
      @(negedge clk);
    end
    chk(t1 - t0 == 17, "R9 trip cycle", t1 - t0, 17);
    flush_cmd();
    repeat (40) @(negedge clk);
    n = 0;
    for (int c = 0; c < 200; c++) begin
      if (c % 10 == 0) drive(0, 32'(c + 1), 1); else wr_en = 0;
      if (mem_req) n++;
      @(negedge clk);
    end
    wr_en = 0;
    chk(n == 0, "R9 no trip at 10-cycle spacing", n, 0);
    flush_cmd();
    cmp_mem("R9 image");

    // R10: fixed window from first write
    tmo_mode = 1;
    repeat (160) @(negedge clk);
    t0 = cyc; t1 = -1;
    for (int c = 0; c < 150; c++) begin
      if (c % 10 == 0) drive(0, 32'(c + 100), 1); else wr_en = 0;
      if (mem_req && t1 < 0) t1 = cyc;
      @(negedge clk);
    end
    wr_en = 0;
    chk(t1 - t0 == 129, "R10 trip cycle", t1 - t0, 129);
    flush_cmd();
    cmp_mem("R10 image");
    tmo_mode = 0;

    // R11: overflow
    gm = 0;
    start_cmd(64);
    for (int k = 0; k < 16; k++) wr(2, 32'h0F1E2D00 + 32'(k), 1);
    chk(overflow == 0, "R11 no overflow at 16", overflow, 0);
    wr(2, 32'hDEADBEEF, 0);
    chk(overflow == 1, "R11 overflow set", overflow, 1);
    gm = 1;
    flush_cmd();
    chk(overflow == 1, "R11 sticky through flush", overflow, 1);
    cmp_mem("R11 dropped word absent");
    start_cmd(16);
    chk(overflow == 0, "R11 cleared by start", overflow, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule